// File: doc/BRIEF.md
# Cumulative Histogram Distance Estimator

This block measures the code distance between the two redundant residue modes of a converter stage. It works purely from statistics of the corrected back-end output. A pseudo-random dither bit selects the residue mode for each conversion. The block keeps one cumulative count for mode-0 samples at a reference code. For mode-1 samples it keeps cumulative counts at eight neighbouring thresholds. After a programmed number of samples it picks the threshold whose count is closest to the mode-0 count. From that threshold it derives a signed distance.

Software or a sequencer pulses start with a reference code, a window offset and a sample budget. Corrected codes then stream in, each tagged with the mode that produced it. A one-cycle done pulse marks the result. The same block serves both the centre-region and boundary-region measurements: the caller runs it once per region with a different reference code, giving the two distances that the calibration loop compares.

Top module: `chd_estimator`

## Requirements
- R1: `mode_o` is taken from bit 0 of a 16-bit maximal-length LFSR (taps 16, 14, 13, 11, never all-zero). It is registered and advances only in cycles with `smp_valid_i` high. Over a long run roughly half of its values are 1.
- R2: A `start_i` pulse clears every counter, latches `ref_code_i`, `win_ofs_i` and `budget_i`, and drives `done_o` to 0 and `dist_o` to 0 in the next cycle. A valid sample presented in the start cycle is not counted. After reset the outputs are in this same cleared state.
- R3: The mode-0 count is the number of accepted samples with `mode_i`=0 and `code_i` less than or equal to the latched reference code q.
- R4: For k = 0..7, mode-1 count k is the number of accepted samples with `mode_i`=1 and `code_i` <= q + ofs + k. The sum is evaluated without wrap-around, so a threshold beyond the largest code counts every mode-1 sample.
- R5: Samples with `smp_valid_i` low are ignored, and so are samples presented after the budget is used up.
- R6: The selected index k minimises |count1[k] - count0|. On a tie the lower k wins.
- R7: `dist_o` = ofs + k - 1 in two's complement. With ofs=0 and k=0 it is -1.
- R8: `done_o` is high for exactly one cycle: the second cycle after the cycle in which the final budgeted sample is presented. With a budget of 0 it is the third cycle after the start cycle, and the result comes from all-zero counts.
- R9: `dist_o` holds its value from the done cycle until the next start. A restart in the middle of a run discards the partial counts.
- R10: Every counter saturates at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears counters, latches configuration, begins a run |
| smp_valid_i | input | 1 | Qualifies `code_i` and `mode_i` |
| code_i | input | CODE_W | Corrected back-end output code |
| mode_i | input | 1 | Residue mode that produced this sample |
| ref_code_i | input | CODE_W | Reference code q |
| win_ofs_i | input | OFS_W | Offset of the first mode-1 threshold above q |
| budget_i | input | BUDGET_W | Number of samples to accumulate |
| mode_o | output | 1 | Pseudo-random residue mode dither bit |
| dist_o | output | OFS_W+2 | Signed distance estimate |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Two pairs of events can fall in the same cycle. The first is a start pulse and a valid sample. The bench provokes it by presenting a mode-0 sample at code q together with start, then feeding a single mode-1 sample one code above the window base. The result is judged on the distance: it reads ofs-1 only if the start-cycle sample was dropped, and ofs if it was counted. The second is the final budgeted sample and the counter update that the match consumes. A run whose best match lies in the top window slot shows whether the last sample reached the counts before the comparison, and the bench checks the done strobe in the exact cycle on both sides.

// File: rtl/chd_pkg.sv
package chd_pkg;

    localparam int CHD_LFSR_W = 16;

    typedef enum logic [1:0] {
        CHD_IDLE,
        CHD_ACC,
        CHD_FIN
    } chd_state_e;

    // Fibonacci shift, taps 16,14,13,11 (maximal length)
    function automatic logic [CHD_LFSR_W-1:0] chd_lfsr_next(input logic [CHD_LFSR_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[CHD_LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/chd_lfsr.sv
module chd_lfsr
    import chd_pkg::*;
#(
    parameter logic [CHD_LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    output logic [CHD_LFSR_W-1:0] state_o
);

    logic [CHD_LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= chd_lfsr_next(state_q);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/chd_hist.sv
module chd_hist #(
    parameter int CODE_W = 12,
    parameter int OFS_W  = 6,
    parameter int CNT_W  = 20,
    parameter int WIN    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       en,
    input  logic [CODE_W-1:0]          code,
    input  logic                       mode,
    input  logic [CODE_W-1:0]          ref_code,
    input  logic [OFS_W-1:0]           ofs,
    output logic [CNT_W-1:0]           cnt0_o,
    output logic [WIN-1:0][CNT_W-1:0]  cnt1_o
);

    localparam int BASE_W = (CODE_W > OFS_W) ? CODE_W : OFS_W;
    localparam int TH_W   = BASE_W + $clog2(WIN) + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TH_W-1:0] code_w;
    logic [TH_W-1:0] base_w;

    assign code_w = TH_W'(code);
    assign base_w = TH_W'(ref_code) + TH_W'(ofs);

    logic [CNT_W-1:0] cnt0_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt0_q <= '0;
        end else if (en && !mode && (code <= ref_code) && (cnt0_q != CNT_MAX)) begin
            cnt0_q <= cnt0_q + 1'b1;
        end
    end

    assign cnt0_o = cnt0_q;

    for (genvar k = 0; k < WIN; k++) begin : g_bin
        logic [TH_W-1:0]  thr;
        logic [CNT_W-1:0] cnt_q;

        assign thr = base_w + TH_W'(k);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q <= '0;
            end else if (en && mode && (code_w <= thr) && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign cnt1_o[k] = cnt_q;
    end

endmodule

// File: rtl/chd_match.sv
module chd_match #(
    parameter int OFS_W = 6,
    parameter int CNT_W = 20,
    parameter int WIN   = 8
) (
    input  logic [CNT_W-1:0]          cnt0,
    input  logic [WIN-1:0][CNT_W-1:0] cnt1,
    input  logic [OFS_W-1:0]          ofs,
    output logic signed [OFS_W+1:0]   dist_o
);

    localparam int IDX_W  = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int DIST_W = OFS_W + 2;

    function automatic logic [CNT_W-1:0] absdiff(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [IDX_W-1:0] best_idx;
    logic [CNT_W-1:0] best_d;
    logic [CNT_W-1:0] cur_d;

    always_comb begin
        best_idx = '0;
        best_d   = absdiff(cnt0, cnt1[0]);
        cur_d    = '0;
        for (int k = 1; k < WIN; k++) begin
            cur_d = absdiff(cnt0, cnt1[k]);
            if (cur_d < best_d) begin
                best_d   = cur_d;
                best_idx = IDX_W'(k);
            end
        end
    end

    logic [DIST_W-1:0] sum;

    assign sum    = DIST_W'(ofs) + DIST_W'(best_idx) - DIST_W'(1);
    assign dist_o = signed'(sum);

endmodule

// File: rtl/chd_estimator.sv
module chd_estimator
    import chd_pkg::*;
#(
    parameter int CODE_W   = 12,
    parameter int OFS_W    = 6,
    parameter int CNT_W    = 20,
    parameter int WIN      = 8,
    parameter int BUDGET_W = 16,
    parameter logic [CHD_LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     smp_valid_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic                     mode_i,
    input  logic [CODE_W-1:0]        ref_code_i,
    input  logic [OFS_W-1:0]         win_ofs_i,
    input  logic [BUDGET_W-1:0]      budget_i,
    output logic                     mode_o,
    output logic signed [OFS_W+1:0]  dist_o,
    output logic                     done_o
);

    chd_state_e            state_q;
    logic [BUDGET_W-1:0]   rem_q;
    logic [CODE_W-1:0]     ref_q;
    logic [OFS_W-1:0]      ofs_q;
    logic signed [OFS_W+1:0] dist_q;
    logic                  done_q;
    logic                  mode_q;

    logic                  cnt_en;
    logic [CNT_W-1:0]      cnt0;
    logic [WIN-1:0][CNT_W-1:0] cnt1;
    logic signed [OFS_W+1:0] dist_calc;
    logic [CHD_LFSR_W-1:0] lfsr_state;

    // ---------------- mode dither ----------------
    chd_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step    (smp_valid_i),
        .state_o (lfsr_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (smp_valid_i) begin
            mode_q <= lfsr_state[0];
        end
    end

    // ---------------- accumulation ----------------
    assign cnt_en = (state_q == CHD_ACC) && smp_valid_i && (rem_q != '0) && !start_i;

    chd_hist #(
        .CODE_W (CODE_W),
        .OFS_W  (OFS_W),
        .CNT_W  (CNT_W),
        .WIN    (WIN)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_i),
        .en       (cnt_en),
        .code     (code_i),
        .mode     (mode_i),
        .ref_code (ref_q),
        .ofs      (ofs_q),
        .cnt0_o   (cnt0),
        .cnt1_o   (cnt1)
    );

    chd_match #(
        .OFS_W (OFS_W),
        .CNT_W (CNT_W),
        .WIN   (WIN)
    ) u_match (
        .cnt0   (cnt0),
        .cnt1   (cnt1),
        .ofs    (ofs_q),
        .dist_o (dist_calc)
    );

    // ---------------- run control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CHD_IDLE;
            rem_q   <= '0;
            ref_q   <= '0;
            ofs_q   <= '0;
            dist_q  <= '0;
            done_q  <= 1'b0;
        end else if (start_i) begin
            state_q <= CHD_ACC;
            rem_q   <= budget_i;
            ref_q   <= ref_code_i;
            ofs_q   <= win_ofs_i;
            dist_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                CHD_ACC: begin
                    if (rem_q == '0) begin
                        state_q <= CHD_FIN;
                    end else if (cnt_en) begin
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == BUDGET_W'(1)) begin
                            state_q <= CHD_FIN;
                        end
                    end
                end
                CHD_FIN: begin
                    dist_q  <= dist_calc;
                    done_q  <= 1'b1;
                    state_q <= CHD_IDLE;
                end
                default: state_q <= CHD_IDLE;
            endcase
        end
    end

    assign mode_o = mode_q;
    assign dist_o = dist_q;
    assign done_o = done_q;

endmodule

// File: rtl/chd_estimator_chk.sv
module chd_estimator_chk #(
    parameter int OFS_W = 6,
    parameter int CNT_W = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input logic                    smp_valid_i,
    input logic                    mode_o,
    input logic signed [OFS_W+1:0] dist_o,
    input logic                    done_o,
    input logic [15:0]             lfsr_state,
    input logic [CNT_W-1:0]        cnt0
);

    // R1
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'h0000);

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid_i |=> $stable(mode_o));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && dist_o == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    dist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (done_o || $stable(dist_o)));

    // R10
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (cnt0 >= $past(cnt0)));

endmodule

bind chd_estimator chd_estimator_chk #(
    .OFS_W (OFS_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .smp_valid_i (smp_valid_i),
    .mode_o      (mode_o),
    .dist_o      (dist_o),
    .done_o      (done_o),
    .lfsr_state  (lfsr_state),
    .cnt0        (cnt0)
);

// File: tb/chd_estimator_tb.sv
module chd_estimator_tb_top;

    typedef struct packed {
        int q;
        int ofs;
        int n0lo;
        int n0hi;
        int c1a;
        int na;
        int c1b;
        int nb;
        int exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{100, 2, 10, 5, 104, 10, 105, 5,  3},   // exact match at k2
        '{ 50, 0,  6, 0,  52,  4,  53, 4,  1},   // tie k2/k3 -> k2
        '{ 10, 1,  3, 0, 500,  7,   0, 0,  0},   // all mode-1 above window
        '{300, 4,  0, 2,   0,  5,   0, 0,  3},   // all mode-1 below window
        '{ 20, 3,  9, 0,  30,  9,   0, 0,  9},   // match in top slot
        '{  5, 0,  0, 1,   5,  3,   0, 0, -1},   // negative estimate
        '{4090, 3, 4, 0, 4094, 2, 4095, 2,  4}   // thresholds past max code
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [11:0] code_i = '0;
    logic        mode_i = 1'b0;
    logic [11:0] ref_code_i = '0;
    logic [5:0]  win_ofs_i = '0;
    logic [15:0] budget_i = '0;

    logic              mode_o, done_o, mode_s, done_s;
    logic signed [7:0] dist_o, dist_s;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    chd_estimator dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i),
        .code_i(code_i), .mode_i(mode_i), .ref_code_i(ref_code_i),
        .win_ofs_i(win_ofs_i), .budget_i(budget_i),
        .mode_o(mode_o), .dist_o(dist_o), .done_o(done_o)
    );

    chd_estimator #(.CNT_W(3)) dut_s (
        .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i),
        .code_i(code_i), .mode_i(mode_i), .ref_code_i(ref_code_i),
        .win_ofs_i(win_ofs_i), .budget_i(budget_i),
        .mode_o(mode_s), .dist_o(dist_s), .done_o(done_s)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic do_start(input int q, input int ofs, input int budget, input bit with_smp);
        ref_code_i  = 12'(q);
        win_ofs_i   = 6'(ofs);
        budget_i    = 16'(budget);
        start_i     = 1'b1;
        smp_valid_i = with_smp;
        code_i      = 12'(q);
        mode_i      = 1'b0;
        @(negedge clk);
        start_i     = 1'b0;
        smp_valid_i = 1'b0;
        code_i      = '0;
    endtask

    task automatic send(input int code, input bit m);
        smp_valid_i = 1'b1;
        code_i      = 12'(code);
        mode_i      = m;
        @(negedge clk);
        smp_valid_i = 1'b0;
        code_i      = '0;
        mode_i      = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // last sample was just sent without gap: check the done timing and value
    task automatic judge(input string req, input int expv);
        chk(done_o == 1'b0, "R8 done early", int'(done_o), 0);
        @(negedge clk);
        chk(done_o == 1'b1, "R8 done strobe", int'(done_o), 1);
        chk(int'(dist_o) == expv, req, int'(dist_o), expv);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 single cycle", int'(done_o), 0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int total, idx, ones, toggles;
        logic prev, held;
        logic signed [7:0] keep;

        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state matches the cleared state
        chk(done_o == 1'b0, "R2 reset done", int'(done_o), 0);
        chk(dist_o == 8'sd0, "R2 reset dist", int'(dist_o), 0);
        chk(mode_o == 1'b0, "R2 reset mode", int'(mode_o), 0);

        // table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            total = VECS[v].n0lo + VECS[v].n0hi + VECS[v].na + VECS[v].nb;
            do_start(VECS[v].q, VECS[v].ofs, total, 1'b0);
            idx = 0;
            for (int i = 0; i < VECS[v].n0lo; i++) begin
                idx++; send(VECS[v].q, 1'b0); if (idx < total) idle(1);
            end
            for (int i = 0; i < VECS[v].n0hi; i++) begin
                idx++; send(VECS[v].q + 1, 1'b0); if (idx < total) idle(1);
            end
            for (int i = 0; i < VECS[v].na; i++) begin
                idx++; send(VECS[v].c1a, 1'b1); if (idx < total) idle(1);
            end
            for (int i = 0; i < VECS[v].nb; i++) begin
                idx++; send(VECS[v].c1b, 1'b1); if (idx < total) idle(1);
            end
            judge("R3/R4/R6/R7 table dist", VECS[v].exp);
        end

        // R9: result held, late samples ignored (R5)
        keep = dist_o;
        send(VECS[NVEC-1].q, 1'b0);
        send(4095, 1'b1);
        idle(3);
        chk(dist_o == keep, "R9 dist held", int'(dist_o), int'(keep));
        chk(done_o == 1'b0, "R5 no second done", int'(done_o), 0);

        // R2: sample in the start cycle is not counted
        do_start(40, 2, 1, 1'b1);
        send(43, 1'b1);
        judge("R2 start-cycle sample", 1);

        // R9: restart in the middle discards partial counts
        do_start(40, 2, 10, 1'b0);
        send(10, 1'b0); send(20, 1'b0); send(30, 1'b0);
        do_start(40, 2, 1, 1'b0);
        send(43, 1'b1);
        judge("R9 restart clears", 1);

        // R8: zero budget
        do_start(40, 5, 0, 1'b0);
        chk(done_o == 1'b0, "R8 zero budget early", int'(done_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 zero budget early2", int'(done_o), 0);
        @(negedge clk);
        chk(done_o == 1'b1, "R8 zero budget done", int'(done_o), 1);
        chk(int'(dist_o) == 4, "R8 zero budget dist", int'(dist_o), 4);
        @(negedge clk);

        // R10: saturation on a 3-bit counter instance
        do_start(10, 1, 17, 1'b0);
        for (int i = 0; i < 10; i++) send(0, 1'b0);
        for (int i = 0; i < 7; i++) send(12, 1'b1);
        @(negedge clk);
        chk(done_s == 1'b1, "R10 sat done", int'(done_s), 1);
        chk(int'(dist_s) == 1, "R10 saturated match", int'(dist_s), 1);
        chk(int'(dist_o) == 1, "R10 wide counter match", int'(dist_o), 1);
        @(negedge clk);

        // R1: dither statistics and stability
        do_start(0, 0, 4000, 1'b0);
        ones = 0;
        toggles = 0;
        prev = mode_o;
        smp_valid_i = 1'b1;
        code_i = '0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (mode_o) ones++;
            if (mode_o != prev) toggles++;
            prev = mode_o;
        end
        smp_valid_i = 1'b0;
        @(negedge clk);
        held = mode_o;
        idle(10);
        chk(ones > 1800 && ones < 2200, "R1 mode balance", ones, 2000);
        chk(toggles > 1000, "R1 mode toggles", toggles, 2000);
        chk(mode_o == held, "R1 mode stable when idle", int'(mode_o), int'(held));

        finish_run();
    end

endmodule